// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows a mobile SDRAM interface from the controller side and works out which low-power state the memory is in. On every clock edge it compares the sampled clock-enable level with the level it registered on the edge before. It combines that comparison with the command decoded from the chip-select, row-strobe, column-strobe and write-enable pins, and with a two-bit bank summary supplied by the bank tracker. From these it reports a single state code. The state codes are normal, precharge power-down, active power-down, self refresh, clock suspend and deep power down.

Alongside the state, the block flags illegal ways of entering or leaving a low-power state. It also watches the quiet window that must follow self-refresh exit. It keeps track of whether the device needs a full initialisation sequence, which is the case after reset and after deep power down, and it flags ordinary traffic that arrives before that sequence has finished. The partial-array refresh setting is not interpreted. It is captured when self refresh is entered and reported on an output. All outputs are registered and change on the clock edge at which the causing inputs are sampled. Reset is synchronous and active high, and reset treats the previous clock-enable level as high.

Top module: `cke_power_ctrl`

## Requirements
- R1: While reset is asserted and on the first edge after it, pwr_state is 0 (normal), need_init is 1, pasr_out is 0, and entry_err, exit_err, srx_viol and uninit_err are 0.
- R2: In normal state, an edge with clock enable falling (previous high, current low) and a quiet command (cs_n high, or cs_n low with ras_n,cas_n,we_n = 111) moves pwr_state to 1 (precharge power-down) for bank_status 00, to 2 (active power-down) for 01, and to 4 (clock suspend) for 10.
- R3: In normal state, clock enable falling with auto refresh (cs_n low, ras_n,cas_n,we_n = 001) and bank_status 00 moves pwr_state to 3 (self refresh).
- R4: In normal state, clock enable falling with burst stop (cs_n low, ras_n,cas_n,we_n = 110) and bank_status 00 moves pwr_state to 5 (deep power down).
- R5: Any other falling-edge combination leaves pwr_state at 0 and pulses entry_err for one cycle. This covers a non-quiet command outside R3/R4, auto refresh or burst stop with banks not idle, and bank_status 11.
- R6: While clock enable is low on both the previous and current edge, pwr_state keeps its value whatever command is on the pins.
- R7: In states 1 to 5, clock enable rising returns pwr_state to 0. A non-quiet command on that edge pulses exit_err when leaving states 1, 2 or 3; leaving state 4 is never flagged.
- R8: For TRC_CYC edges after the self-refresh exit edge, every non-quiet command pulses srx_viol on the following cycle; the edge after that window is not checked.
- R9: Leaving deep power down sets need_init to 1.
- R10: need_init clears on a mode-register set (ras_n,cas_n,we_n = 000) that follows a precharge-all (010 with a10 high) and INIT_REFS auto refreshes. A precharge-all before completion restarts the count. Other commands neither advance nor restart it.
- R11: With need_init at 1, pwr_state 0 and clock enable high on both edges, an activate (011), read (101), write (100) or burst stop (110) pulses uninit_err.
- R12: pasr_out takes pasr_in on the self-refresh entry edge and holds that value until the next such entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Sampled clock-enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit selecting precharge of all banks |
| bank_status | input | 2 | 00 all idle, 01 a row open, 10 burst running, 11 invalid |
| pasr_in | input | PASR_W | Partial-array refresh setting to report |
| pwr_state | output | 3 | Current state code |
| pasr_out | output | PASR_W | Setting captured at self-refresh entry |
| entry_err | output | 1 | Illegal low-power entry pulse |
| exit_err | output | 1 | Illegal low-power exit pulse |
| srx_viol | output | 1 | Command inside the post-self-refresh window |
| uninit_err | output | 1 | Ordinary command before initialisation |
| need_init | output | 1 | Full initialisation sequence outstanding |

## Verification
The self-refresh guard window and a new low-power entry can land on the same edge. A burst stop issued with clock enable falling two edges after self-refresh exit is both a legal entry into deep power down and a forbidden command inside the quiet window. The bench provokes exactly that case and expects, on one sampled cycle, pwr_state at 5 together with srx_viol at 1. It then checks that the following exit raises need_init.

// File: rtl/cke_pm_pkg.sv
package cke_pm_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL   = 3'd0,
    PS_PRE_PD   = 3'd1,
    PS_ACT_PD   = 3'd2,
    PS_SELF_REF = 3'd3,
    PS_SUSPEND  = 3'd4,
    PS_DEEP_PD  = 3'd5
  } pwr_state_e;

  typedef enum logic [3:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_BST,
    CMD_PRE,
    CMD_PRE_ALL,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_BURST = 2'd2,
    BK_BAD   = 2'd3
  } bank_e;

  function automatic logic is_traffic(cmd_e c);
    return (c == CMD_ACT) || (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_BST);
  endfunction

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
  import cke_pm_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = a10 ? CMD_PRE_ALL : CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
  import cke_pm_pkg::*;
#(
  parameter int PASR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cke_q,
  input  cmd_e              cmd,
  input  bank_e             bank,
  input  logic [PASR_W-1:0] pasr_in,
  output pwr_state_e        state,
  output logic              entry_err,
  output logic              exit_err,
  output logic [PASR_W-1:0] pasr_out,
  output logic              srx_exit,
  output logic              dpd_exit,
  output logic              normal_op
);

  pwr_state_e nxt;
  logic       ent_e;
  logic       ex_e;
  logic       falling;
  logic       rising;

  assign falling   = cke_q && !cke;
  assign rising    = !cke_q && cke;
  assign normal_op = (state == PS_NORMAL) && cke_q && cke;

  always_comb begin
    nxt      = state;
    ent_e    = 1'b0;
    ex_e     = 1'b0;
    srx_exit = 1'b0;
    dpd_exit = 1'b0;
    if (state == PS_NORMAL) begin
      if (falling) begin
        case (cmd)
          CMD_NOP: begin
            case (bank)
              BK_IDLE:  nxt = PS_PRE_PD;
              BK_OPEN:  nxt = PS_ACT_PD;
              BK_BURST: nxt = PS_SUSPEND;
              default:  ent_e = 1'b1;
            endcase
          end
          CMD_REF: begin
            if (bank == BK_IDLE) nxt = PS_SELF_REF;
            else                 ent_e = 1'b1;
          end
          CMD_BST: begin
            if (bank == BK_IDLE) nxt = PS_DEEP_PD;
            else                 ent_e = 1'b1;
          end
          default: ent_e = 1'b1;
        endcase
      end
    end else if (rising) begin
      nxt = PS_NORMAL;
      case (state)
        PS_PRE_PD, PS_ACT_PD: ex_e = (cmd != CMD_NOP);
        PS_SELF_REF: begin
          ex_e     = (cmd != CMD_NOP);
          srx_exit = 1'b1;
        end
        PS_DEEP_PD: dpd_exit = 1'b1;
        default: ex_e = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_NORMAL;
      entry_err <= 1'b0;
      exit_err  <= 1'b0;
      pasr_out  <= '0;
    end else begin
      state     <= nxt;
      entry_err <= ent_e;
      exit_err  <= ex_e;
      if ((state == PS_NORMAL) && (nxt == PS_SELF_REF))
        pasr_out <= pasr_in;
    end
  end

endmodule

// File: rtl/cke_srx_guard.sv
module cke_srx_guard
  import cke_pm_pkg::*;
#(
  parameter int TRC_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cmd_e cmd,
  output logic viol
);

  localparam int CW = $clog2(TRC_CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(TRC_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      viol <= 1'b0;
    end else begin
      viol <= (cnt != '0) && (cmd != CMD_NOP);
      if (load)            cnt <= LOAD_V;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cke_init_track.sv
module cke_init_track
  import cke_pm_pkg::*;
#(
  parameter int INIT_REFS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_en,
  input  logic restart,
  input  cmd_e cmd,
  output logic need_init,
  output logic uninit_err
);

  localparam int RW = $clog2(INIT_REFS + 1);
  localparam logic [RW-1:0] LAST_REF = RW'(INIT_REFS - 1);

  typedef enum logic [1:0] {
    IS_WAIT_PRE,
    IS_REFS,
    IS_WAIT_MRS,
    IS_DONE
  } init_step_e;

  init_step_e    step;
  logic [RW-1:0] refs;

  assign need_init = (step != IS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= IS_WAIT_PRE;
      refs       <= '0;
      uninit_err <= 1'b0;
    end else begin
      uninit_err <= adv_en && need_init && is_traffic(cmd);
      if (restart) begin
        step <= IS_WAIT_PRE;
        refs <= '0;
      end else if (adv_en && need_init) begin
        if (cmd == CMD_PRE_ALL) begin
          step <= IS_REFS;
          refs <= '0;
        end else begin
          case (step)
            IS_REFS: begin
              if (cmd == CMD_REF) begin
                if (refs == LAST_REF) step <= IS_WAIT_MRS;
                else                  refs <= refs + 1'b1;
              end
            end
            IS_WAIT_MRS: begin
              if (cmd == CMD_MRS) step <= IS_DONE;
            end
            default: step <= step;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
  import cke_pm_pkg::*;
#(
  parameter int PASR_W    = 3,
  parameter int TRC_CYC   = 4,
  parameter int INIT_REFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              a10,
  input  logic [1:0]        bank_status,
  input  logic [PASR_W-1:0] pasr_in,
  output logic [2:0]        pwr_state,
  output logic [PASR_W-1:0] pasr_out,
  output logic              entry_err,
  output logic              exit_err,
  output logic              srx_viol,
  output logic              uninit_err,
  output logic              need_init
);

  cmd_e       cmd;
  pwr_state_e state;
  logic       cke_q;
  logic       srx_exit;
  logic       dpd_exit;
  logic       normal_op;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  cke_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .a10   (a10),
    .cmd   (cmd)
  );

  cke_pwr_fsm #(.PASR_W(PASR_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cke_q     (cke_q),
    .cmd       (cmd),
    .bank      (bank_e'(bank_status)),
    .pasr_in   (pasr_in),
    .state     (state),
    .entry_err (entry_err),
    .exit_err  (exit_err),
    .pasr_out  (pasr_out),
    .srx_exit  (srx_exit),
    .dpd_exit  (dpd_exit),
    .normal_op (normal_op)
  );

  cke_srx_guard #(.TRC_CYC(TRC_CYC)) u_guard (
    .clk  (clk),
    .rst  (rst),
    .load (srx_exit),
    .cmd  (cmd),
    .viol (srx_viol)
  );

  cke_init_track #(.INIT_REFS(INIT_REFS)) u_init (
    .clk        (clk),
    .rst        (rst),
    .adv_en     (normal_op),
    .restart    (dpd_exit),
    .cmd        (cmd),
    .need_init  (need_init),
    .uninit_err (uninit_err)
  );

  assign pwr_state = state;

endmodule

// File: rtl/cke_power_ctrl_chk.sv
module cke_power_ctrl_chk #(
  parameter int PASR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        bank_status,
  input logic [2:0]        pwr_state,
  input logic [PASR_W-1:0] pasr_out,
  input logic              need_init,
  input logic              uninit_err
);

  logic prev_cke;
  always_ff @(posedge clk) begin
    if (rst) prev_cke <= 1'b1;
    else     prev_cke <= cke;
  end

  // R2: the state code never leaves the six defined values
  assert_state_legal_R2: assert property (@(posedge clk) disable iff (rst)
    pwr_state <= 3'd5);

  assert_low_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!prev_cke && !cke) |=> $stable(pwr_state));

  assert_sref_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd0 && prev_cke && !cke && !cs_n &&
     {ras_n, cas_n, we_n} == 3'b001 && bank_status == 2'b00) |=> (pwr_state == 3'd3));

  assert_wake_R7: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state inside {3'd1, 3'd2, 3'd3, 3'd4}) && cke) |=> (pwr_state == 3'd0));

  assert_dpd_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd5 && cke) |=> (pwr_state == 3'd0 && need_init));

  assert_uninit_flag_R11: assert property (@(posedge clk) disable iff (rst)
    uninit_err |-> $past(need_init));

  assert_pasr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd3) |=> $stable(pasr_out));

endmodule

bind cke_power_ctrl cke_power_ctrl_chk #(.PASR_W(PASR_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .bank_status (bank_status),
  .pwr_state   (pwr_state),
  .pasr_out    (pasr_out),
  .need_init   (need_init),
  .uninit_err  (uninit_err)
);

// File: tb/test_cke_power_ctrl.sv
`timescale 1ns/1ps
module test_cke_power_ctrl;

  localparam int PW  = 3;
  localparam int TRC = 4;

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_BST = 3'b110, C_PRE = 3'b010, C_REF = 3'b001,
                         C_MRS = 3'b000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke = 1'b1;
  logic          cs_n = 1'b0;
  logic [2:0]    rcw = C_NOP;
  logic          a10 = 1'b0;
  logic [1:0]    bank_status = 2'b00;
  logic [PW-1:0] pasr_in = '0;
  logic [2:0]    pwr_state;
  logic [PW-1:0] pasr_out;
  logic          entry_err, exit_err, srx_viol, uninit_err, need_init;

  int vectors = 0;
  int miscomp = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cke_power_ctrl #(.PASR_W(PW), .TRC_CYC(TRC), .INIT_REFS(2)) i_cke_power_ctrl (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n),
    .ras_n(rcw[2]), .cas_n(rcw[1]), .we_n(rcw[0]), .a10(a10),
    .bank_status(bank_status), .pasr_in(pasr_in),
    .pwr_state(pwr_state), .pasr_out(pasr_out), .entry_err(entry_err),
    .exit_err(exit_err), .srx_viol(srx_viol), .uninit_err(uninit_err),
    .need_init(need_init)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic k, input logic [2:0] c);
    cke = k; cs_n = 1'b0; rcw = c; a10 = (c == C_PRE);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic init_seq();
    drive(1, C_PRE); tick();
    drive(1, C_REF); tick();
    drive(1, C_REF); tick();
    drive(1, C_MRS); tick();
    drive(1, C_NOP); tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; drive(1, C_NOP);
    repeat (3) tick();
    chk("R1", "state in reset", pwr_state, 0);
    rst = 1'b0; tick();
    chk("R1", "state", pwr_state, 0);
    chk("R1", "need_init", need_init, 1);
    chk("R1", "pasr_out", pasr_out, 0);
    chk("R1", "flags", {entry_err, exit_err, srx_viol, uninit_err}, 0);
  endtask

  task automatic t_init();
    drive(1, C_ACT); tick();
    chk("R11", "uninit_err on activate", uninit_err, 1);
    drive(1, C_NOP); tick();
    chk("R11", "uninit_err on nop", uninit_err, 0);
    drive(1, C_REF); tick();
    drive(1, C_PRE); tick();
    drive(1, C_REF); tick();
    drive(1, C_MRS); tick();
    chk("R10", "need_init after one refresh", need_init, 1);
    init_seq();
    chk("R10", "need_init after full sequence", need_init, 0);
    drive(1, C_RD); tick();
    chk("R11", "no uninit_err once initialised", uninit_err, 0);
  endtask

  task automatic t_power_down();
    bank_status = 2'b00; drive(0, C_NOP); tick();
    chk("R2", "precharge power-down", pwr_state, 1);
    drive(0, C_ACT); tick();
    chk("R6", "hold with command while low", pwr_state, 1);
    chk("R6", "no entry_err while held", entry_err, 0);
    drive(1, C_NOP); tick();
    chk("R7", "exit to normal", pwr_state, 0);
    chk("R7", "clean exit", exit_err, 0);
    bank_status = 2'b01; drive(0, C_NOP); tick();
    chk("R2", "active power-down", pwr_state, 2);
    drive(1, C_ACT); tick();
    chk("R7", "exit state", pwr_state, 0);
    chk("R7", "exit_err with activate", exit_err, 1);
    drive(1, C_NOP); tick();
    chk("R7", "exit_err one cycle", exit_err, 0);
  endtask

  task automatic t_suspend();
    bank_status = 2'b10; cke = 1'b0; cs_n = 1'b1; rcw = C_ACT; tick();
    chk("R2", "clock suspend via deselect", pwr_state, 4);
    drive(1, C_RD); tick();
    chk("R7", "suspend exit state", pwr_state, 0);
    chk("R7", "suspend exit not flagged", exit_err, 0);
    bank_status = 2'b00;
  endtask

  task automatic t_self_refresh();
    pasr_in = 3'd5; drive(0, C_REF); tick();
    chk("R3", "self refresh entry", pwr_state, 3);
    chk("R12", "pasr captured", pasr_out, 5);
    pasr_in = 3'd2; drive(0, C_NOP); tick();
    chk("R12", "pasr held", pasr_out, 5);
    drive(1, C_NOP); tick();
    chk("R7", "self refresh exit", pwr_state, 0);
    for (int i = 0; i < TRC - 1; i++) begin
      drive(1, C_NOP); tick();
      chk("R8", "quiet window nop", srx_viol, 0);
    end
    drive(1, C_ACT); tick();
    chk("R8", "activate on last window edge", srx_viol, 1);
    drive(1, C_ACT); tick();
    chk("R8", "activate after window", srx_viol, 0);
    drive(0, C_REF); tick();
    drive(1, C_MRS); tick();
    chk("R7", "self refresh exit with command", exit_err, 1);
    drive(1, C_NOP); repeat (TRC) tick();
    bank_status = 2'b01; drive(0, C_REF); tick();
    chk("R5", "refresh with open row state", pwr_state, 0);
    chk("R5", "refresh with open row flag", entry_err, 1);
    bank_status = 2'b00; drive(1, C_NOP); tick();
    chk("R5", "entry_err one cycle", entry_err, 0);
  endtask

  task automatic t_illegal();
    drive(0, C_ACT); tick();
    chk("R5", "activate on falling cke", entry_err, 1);
    chk("R5", "state stays normal", pwr_state, 0);
    drive(1, C_NOP); tick();
    bank_status = 2'b11; drive(0, C_NOP); tick();
    chk("R5", "invalid bank code", entry_err, 1);
    drive(1, C_NOP); tick();
    bank_status = 2'b01; drive(0, C_BST); tick();
    chk("R5", "burst stop with open row", entry_err, 1);
    chk("R4", "no deep power down with open row", pwr_state, 0);
    bank_status = 2'b00; drive(1, C_NOP); tick();
  endtask

  task automatic t_deep();
    drive(0, C_BST); tick();
    chk("R4", "deep power down entry", pwr_state, 5);
    drive(0, C_ACT); tick();
    chk("R6", "deep power down held", pwr_state, 5);
    drive(1, C_NOP); tick();
    chk("R9", "deep exit state", pwr_state, 0);
    chk("R9", "need_init after deep exit", need_init, 1);
    drive(1, C_RD); tick();
    chk("R11", "read before re-init", uninit_err, 1);
    init_seq();
    chk("R10", "re-init complete", need_init, 0);
  endtask

  task automatic t_overlap();
    drive(0, C_REF); tick();
    drive(1, C_NOP); tick();
    drive(1, C_NOP); tick();
    drive(0, C_BST); tick();
    chk("R4", "deep entry inside window", pwr_state, 5);
    chk("R8", "window violation same edge", srx_viol, 1);
    drive(1, C_NOP); tick();
    chk("R9", "need_init after overlap exit", need_init, 1);
    init_seq();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      miscomp++;
      vectors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_init();
    t_power_down();
    t_suspend();
    t_self_refresh();
    t_illegal();
    t_deep();
    t_overlap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule